// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block moves a block of 32-bit words out of a memory and onto a streaming output. A controller sets a source offset and a byte length through a small register port, then writes a start command. The block turns the offset into an absolute address by adding a fixed memory base. It issues one read request at a time on a request/response memory port. Each returned word goes out on a stream with valid, ready and last.

The start command is answered at once. If the channel is idle and the length is usable, the transfer begins in the background. If the channel is already running, or the length is zero or not a whole number of words, the command is dropped and a sticky error flag is raised. Software has two ways to learn that a transfer has finished. It can block on the `done_o` pin, which stays high until cleared. It can also poll the status register. Done and error are both cleared by writing a one to their bit.

Top module: `m2s_dma`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_valid` and `st_valid` are 0, and the status register (byte offset 0x4) reads 0.
- R2: Writing bit 0 = 1 to the control register (offset 0x0) while idle, with a nonzero length that is a multiple of 4, sets `busy_o` from the next cycle. The block then reads length/4 words from addresses base+offset, base+offset+4, and so on upward, and emits them on the stream in that order without loss or repetition.
- R3: `st_last` is 1 on the final word of a transfer and 0 on every other word.
- R4: While `st_valid` is 1 and `st_ready` is 0, `st_data` and `st_last` hold steady and no new memory request is raised.
- R5: A raised memory request keeps `mem_req_valid` at 1 and holds its address until `mem_req_ready` accepts it.
- R6: A start written while busy is ignored: the running transfer continues unchanged (including after a later offset write), and status bit 2 (error) becomes 1.
- R7: A start with a length of zero, or a length not a multiple of 4, raises status bit 2. It issues no memory request and leaves `busy_o` at 0.
- R8: On the clock edge that accepts the last stream word, `busy_o` falls and `done_o` rises. Both changes are visible in the following cycle.
- R9: Done (status bit 1) and error (status bit 2) are sticky and are cleared by writing 1 to their bit at offset 0x4. When completion and a done-clear fall on the same edge, done ends up set.
- R10: The offset register (0x8) and the byte-count register (0xC) read back what was written. Status bit 0 mirrors busy, and the control register reads 0.
- R11: An accepted start clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| st_valid | output | 1 | Stream word present |
| st_ready | input | 1 | Stream consumer accepts |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of transfer |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | Sticky completion flag |

## Verification
Completion and a software clear of done can land on the same clock edge. In that case the hardware set must win, or a blocking waiter would miss the finish. The bench holds the stream consumer stalled on a one-word transfer until the word is offered. It then raises ready and writes 1 to the done bit in the same cycle. After that edge it expects `done_o` high and `busy_o` low. A second same-edge case is a start written while a transfer runs; there the error flag must rise and the transfer's data must still match the first offset.

// File: rtl/m2s_dma_pkg.sv
package m2s_dma_pkg;
  localparam int WORD_W   = 32;
  localparam int WORD_B   = WORD_W / 8;
  localparam int REG_AW   = 4;

  // register index = byte offset / 4
  localparam logic [1:0] RIDX_CTRL = 2'd0;
  localparam logic [1:0] RIDX_STAT = 2'd1;
  localparam logic [1:0] RIDX_OFFS = 2'd2;
  localparam logic [1:0] RIDX_LEN  = 2'd3;

  localparam int BIT_START = 0;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_ERR   = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_SEND = 2'd3
  } seq_state_t;
endpackage

// File: rtl/m2s_dma_regs.sv
module m2s_dma_regs
  import m2s_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              busy_i,
  input  logic              finish_i,
  output logic              start_o,
  output logic [AW-1:0]     offs_o,
  output logic [LW-1:0]     len_o,
  output logic              done_o
);
  logic [AW-1:0] offs_q, offs_d;
  logic [LW-1:0] len_q, len_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          wr_en, start_req, len_ok, stat_wr;
  logic [1:0]    ridx;

  assign ridx      = cfg_addr[REG_AW-1:2];
  assign wr_en     = cfg_sel && cfg_wr;
  assign start_req = wr_en && (ridx == RIDX_CTRL) && cfg_wdata[BIT_START];
  assign len_ok    = (len_q[1:0] == 2'b00) && (len_q != '0);
  assign start_o   = start_req && !busy_i && len_ok;
  assign stat_wr   = wr_en && (ridx == RIDX_STAT);

  always_comb begin
    offs_d = offs_q;
    len_d  = len_q;
    done_d = done_q;
    err_d  = err_q;
    if (wr_en && (ridx == RIDX_OFFS)) offs_d = cfg_wdata[AW-1:0];
    if (wr_en && (ridx == RIDX_LEN))  len_d  = cfg_wdata[LW-1:0];
    if (stat_wr && cfg_wdata[BIT_DONE]) done_d = 1'b0;
    if (start_o)                        done_d = 1'b0;
    if (finish_i)                       done_d = 1'b1;
    if (stat_wr && cfg_wdata[BIT_ERR])  err_d  = 1'b0;
    if (start_req && !start_o)          err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      offs_q <= offs_d;
      len_q  <= len_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (ridx)
      RIDX_STAT: begin
        cfg_rdata[BIT_BUSY] = busy_i;
        cfg_rdata[BIT_DONE] = done_q;
        cfg_rdata[BIT_ERR]  = err_q;
      end
      RIDX_OFFS: cfg_rdata[AW-1:0] = offs_q;
      RIDX_LEN:  cfg_rdata[LW-1:0] = len_q;
      default:   cfg_rdata = '0;
    endcase
  end

  assign offs_o = offs_q;
  assign len_o  = len_q;
  assign done_o = done_q;

  // R2: accepted start makes the sequencer busy next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_i);
  // R8: completion drops busy and sets done together
  assert_finish_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> (done_q && !busy_i));
  // R6: a start while running raises error and does not restart
  assert_busy_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy_i) |=> err_q);
endmodule

// File: rtl/m2s_dma_seq.sv
module m2s_dma_seq
  import m2s_dma_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          LW       = 16,
  parameter logic [15:0] MEM_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     offs_i,
  input  logic [LW-1:0]     len_i,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data,
  output logic              st_last,
  output logic              busy_o,
  output logic              finish_o
);
  localparam int CW = LW - 1;
  localparam logic [AW-1:0] BASE_A = AW'(MEM_BASE);

  seq_state_t        st_q, st_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [CW-1:0]     left_q, left_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              last_word;

  assign last_word = (left_q == CW'(1));

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    left_d   = left_q;
    data_d   = data_q;
    finish_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        addr_d = BASE_A + offs_i;
        left_d = len_i[LW-1:2];
        st_d   = SQ_REQ;
      end
      SQ_REQ:  if (mem_req_ready) st_d = SQ_WAIT;
      SQ_WAIT: if (mem_rsp_valid) begin
        data_d = mem_rsp_data;
        st_d   = SQ_SEND;
      end
      SQ_SEND: if (st_ready) begin
        if (last_word) begin
          finish_o = 1'b1;
          st_d     = SQ_IDLE;
        end else begin
          left_d = left_q - CW'(1);
          addr_d = addr_q + AW'(WORD_B);
          st_d   = SQ_REQ;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      data_q <= data_d;
    end
  end

  assign mem_req_valid = (st_q == SQ_REQ);
  assign mem_req_addr  = addr_q;
  assign st_valid      = (st_q == SQ_SEND);
  assign st_data       = data_q;
  assign st_last       = st_valid && last_word;
  assign busy_o        = (st_q != SQ_IDLE);

  // R5: pending request is held with a steady address
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R4: stalled stream word is held
  assert_stream_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));
  // R3: nothing follows the final word
  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_last) |=> (!st_valid && !busy_o));
endmodule

// File: rtl/m2s_dma.sv
module m2s_dma
  import m2s_dma_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          LW       = 16,
  parameter logic [15:0] MEM_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data,
  output logic              st_last,
  output logic              busy_o,
  output logic              done_o
);
  logic          rst_s1_q, rst_s2_q;
  logic          start_w, finish_w;
  logic [AW-1:0] offs_w;
  logic [LW-1:0] len_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  m2s_dma_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .cfg_sel   (cfg_sel),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy_i    (busy_o),
    .finish_i  (finish_w),
    .start_o   (start_w),
    .offs_o    (offs_w),
    .len_o     (len_w),
    .done_o    (done_o)
  );

  m2s_dma_seq #(.AW(AW), .LW(LW), .MEM_BASE(MEM_BASE)) u_seq (
    .clk           (clk),
    .rst_n         (rst_s2_q),
    .start_i       (start_w),
    .offs_i        (offs_w),
    .len_i         (len_w),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .st_data       (st_data),
    .st_last       (st_last),
    .busy_o        (busy_o),
    .finish_o      (finish_w)
  );
endmodule

// File: tb/m2s_dma_tb_top.sv
module m2s_dma_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 16;
  localparam logic [15:0] BASE       = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0, cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = 4'h0;
  logic [31:0] cfg_wdata = 32'h0, cfg_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;
  logic        st_valid, st_ready, st_last, busy_o, done_o;
  logic [31:0] st_data;

  logic [15:0] lfsr = 16'hACE1;
  logic        p1_v = 1'b0;
  logic [15:0] p1_a = 16'h0;
  logic        rdy_rand = 1'b0, rdy_man = 1'b1, mr_rand = 1'b0;

  int checks = 0, fails = 0;
  int idx = 0, exp_words = 0;
  logic [15:0] exp_base = 16'h0;
  int stall_req_err = 0, hold_err = 0, req_err = 0, req_cnt = 0;
  logic prev_sv = 1'b0, prev_sr = 1'b0, prev_sl = 1'b0, prev_mv = 1'b0, prev_mr = 1'b0;
  logic [31:0] prev_sd = 32'h0;
  logic [15:0] prev_ma = 16'h0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign st_ready      = rdy_rand ? lfsr[0] : rdy_man;
  assign mem_req_ready = mr_rand ? lfsr[5] : 1'b1;

  m2s_dma #(.AW(AW), .LW(16), .MEM_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .st_last(st_last), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {a ^ 16'h5AC3, a};
  endfunction

  // memory model: fixed two-cycle read latency
  always @(posedge clk) begin
    lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    p1_v          <= mem_req_valid && mem_req_ready;
    p1_a          <= mem_req_addr;
    mem_rsp_valid <= p1_v;
    mem_rsp_data  <= word_of(p1_a);
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (st_valid && st_ready) begin
        checks++;
        if (idx >= exp_words || st_data !== word_of(exp_base + 16'(4*idx))) begin
          fails++;
          $display("FAIL R2 word %0d: actual %h expected %h", idx, st_data,
                   word_of(exp_base + 16'(4*idx)));
        end
        checks++;
        if (st_last !== (idx == exp_words-1)) begin
          fails++;
          $display("FAIL R3 last on word %0d: actual %b expected %b", idx, st_last,
                   (idx == exp_words-1));
        end
        idx++;
      end
      if (prev_sv && !prev_sr && !(st_valid && st_data == prev_sd && st_last == prev_sl))
        hold_err++;
      if (st_valid && !st_ready && mem_req_valid) stall_req_err++;
      if (prev_mv && !prev_mr && !(mem_req_valid && mem_req_addr == prev_ma)) req_err++;
      if (mem_req_valid && mem_req_ready) req_cnt++;
    end
    prev_sv = st_valid; prev_sr = st_ready; prev_sd = st_data; prev_sl = st_last;
    prev_mv = mem_req_valid; prev_mr = mem_req_ready; prev_ma = mem_req_addr;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_sel = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_sel = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done_o; i++) step(1);
  endtask

  task automatic arm(input logic [15:0] off, input int bytes);
    exp_base = BASE + off; exp_words = bytes / 4; idx = 0;
    reg_wr(4'h8, {16'h0, off});
    reg_wr(4'hC, 32'(bytes));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(4'h4, d);
    chk(d == 0, "R1 status", d, 0);
    chk(!busy_o && !done_o, "R1 busy/done", {busy_o, done_o}, 0);
    chk(!mem_req_valid && !st_valid, "R1 req/valid", {mem_req_valid, st_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_wr(4'h8, 32'h0000_1234);
    reg_wr(4'hC, 32'h0000_0ABC);
    reg_rd(4'h8, d); chk(d == 32'h1234, "R10 offset", d, 32'h1234);
    reg_rd(4'hC, d); chk(d == 32'h0ABC, "R10 count", d, 32'h0ABC);
    reg_rd(4'h0, d); chk(d == 0, "R10 control", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    rdy_rand = 0; mr_rand = 0; rdy_man = 1;
    arm(16'h0040, 16);
    reg_wr(4'h0, 32'h1);
    chk(busy_o == 1, "R2 busy rises", busy_o, 1);
    reg_rd(4'h4, d); chk(d[0] == 1, "R10 status busy", d[0], 1);
    wait_done();
    step(1);
    chk(idx == 4, "R2 word count", idx, 4);
    reg_rd(4'h4, d); chk(d == 32'h2, "R8 status done", d, 2);
  endtask

  task automatic t_backpressure();
    int r0;
    rdy_rand = 1; mr_rand = 1;
    stall_req_err = 0; hold_err = 0; req_err = 0; r0 = req_cnt;
    arm(16'h0100, 40);
    reg_wr(4'h0, 32'h1);
    chk(done_o == 0, "R11 done cleared", done_o, 0);
    wait_done();
    step(1);
    chk(idx == 10, "R4 no loss/dup", idx, 10);
    chk(req_cnt - r0 == 10, "R4 request count", req_cnt - r0, 10);
    chk(stall_req_err == 0, "R4 no fetch in stall", stall_req_err, 0);
    chk(hold_err == 0, "R4 stream hold", hold_err, 0);
    chk(req_err == 0, "R5 request hold", req_err, 0);
    rdy_rand = 0; mr_rand = 0; rdy_man = 1;
    reg_wr(4'h4, 32'h6);
  endtask

  task automatic t_busy_start();
    logic [31:0] d;
    rdy_man = 0;
    arm(16'h0200, 32);
    reg_wr(4'h0, 32'h1);
    reg_wr(4'h8, 32'h0300);
    reg_wr(4'h0, 32'h1);
    reg_rd(4'h4, d);
    chk(d[2] == 1 && d[0] == 1, "R6 error while busy", d, 5);
    rdy_rand = 1;
    wait_done();
    step(1);
    rdy_rand = 0; rdy_man = 1;
    chk(idx == 8, "R6 original transfer kept", idx, 8);
    reg_wr(4'h4, 32'h6);
    reg_rd(4'h4, d); chk(d == 0, "R9 w1c clears", d, 0);
  endtask

  task automatic t_bad_len();
    logic [31:0] d;
    int r0;
    r0 = req_cnt;
    arm(16'h0, 10);
    reg_wr(4'h0, 32'h1);
    reg_rd(4'h4, d); chk(d == 32'h4, "R7 odd length error", d, 4);
    reg_wr(4'h4, 32'h4);
    arm(16'h0, 0);
    reg_wr(4'h0, 32'h1);
    step(8);
    reg_rd(4'h4, d); chk(d == 32'h4, "R7 zero length error", d, 4);
    chk(req_cnt == r0, "R7 no request", req_cnt - r0, 0);
    reg_wr(4'h4, 32'h4);
  endtask

  task automatic t_same_edge();
    logic [31:0] d;
    rdy_man = 0;
    arm(16'h0020, 4);
    reg_wr(4'h0, 32'h1);
    for (int i = 0; i < 50 && !st_valid; i++) step(1);
    chk(busy_o == 1, "R8 busy before last", busy_o, 1);
    rdy_man = 1;
    reg_wr(4'h4, 32'h2);
    chk(busy_o == 0, "R8 busy falls", busy_o, 0);
    chk(done_o == 1, "R9 set wins over clear", done_o, 1);
    reg_rd(4'h4, d); chk(d == 32'h2, "R9 status after same edge", d, 2);
    chk(idx == 1, "R3 single word", idx, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_regs();
    t_basic();
    t_backpressure();
    t_busy_start();
    t_bad_len();
    t_same_edge();
    step(4);
    finish_run();
  end
endmodule